// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes handed over on a valid/ready interface into asynchronous serial frames on a single line. The line rests high. Each frame has four parts in this order: a low start bit, then the character sent least-significant bit first, then an optional parity bit, then one high stop bit. A bit-rate tick, produced elsewhere, sets the pace. Every bit stays on the line for exactly one tick period.

The character length and the parity rule come from a five-bit mode field. The block samples that field, together with the byte, at the moment it takes the byte. Changing the field later does not affect a frame that is already in progress. A transmit-enable input gates whether new bytes are taken. Dropping it during a frame lets that frame run to the end.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, and it is high whenever the block is idle and ready.
- R2: `in_ready` is high only when the block is idle and `tx_en` is high. While `tx_en` is low, no byte is taken and the line stays high.
- R3: A frame is one low start bit, then the data bits least-significant first, then the parity bit when parity is on, then one high stop bit.
- R4: Mode bits [2:1] set the character length: 00 and 01 give 8 bits, 10 gives 7 bits and 11 gives 6 bits. Only the low bits of the byte are sent.
- R5: Mode bits [5:3] set the parity rule: 000 even (the data bits plus the parity bit hold an even count of ones), 001 odd, 010 always 0, 011 always 1, and any value with bit 5 set means no parity bit.
- R6: The line changes only on a clock edge at which `tick` is high. The start bit begins at the first tick edge strictly after the edge that takes the byte. Each later bit begins at the following tick edge.
- R7: The mode is sampled at the edge that takes the byte. Changing the mode during a frame has no effect on that frame.
- R8: If `tx_en` falls during a frame, that frame still completes in full.
- R9: `in_ready` is low from the edge after a byte is taken until the tick edge that ends the stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle bit-rate pulse |
| tx_en | input | 1 | Transmit enable |
| mode | input | 5 | Mode field bits [5:1]: length in [2:1], parity in [5:3] |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| txd | output | 1 | Serial line, idles high |

## Verification
Taking a byte and receiving a bit-rate tick can happen in the same clock cycle. The bench provokes this by lining up each offer against every phase of a four-cycle tick. It then requires that the start bit always begins at the next tick, never at the tick that coincides with the take. The second same-cycle pairing is a fall of the enable, or a change of mode, in the cycle right after a take. The bench judges it by decoding the whole frame at tick edges and comparing it with the frame computed from the byte and the mode that were sampled at the take.

// File: rtl/uft_pkg.sv
`timescale 1ns/1ps
package uft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PK_EVEN = 2'b00,
    PK_ODD  = 2'b01,
    PK_ZERO = 2'b10,
    PK_ONE  = 2'b11
  } par_kind_e;

  // len_trim: how many bits below the full width the character is (0, 1 or 2)
  typedef struct packed {
    logic      par_on;
    par_kind_e kind;
    logic [1:0] len_trim;
  } frame_cfg_t;

endpackage

// File: rtl/uft_mode_decode.sv
`timescale 1ns/1ps
module uft_mode_decode
  import uft_pkg::*;
(
  input  logic [5:1]  mode,
  output frame_cfg_t  cfg
);

  always_comb begin
    cfg = '0;
    unique case (mode[2:1])
      2'b10:   cfg.len_trim = 2'd1;
      2'b11:   cfg.len_trim = 2'd2;
      default: cfg.len_trim = 2'd0;
    endcase
    cfg.par_on = ~mode[5];
    cfg.kind   = par_kind_e'(mode[4:3]);
  end

endmodule

// File: rtl/uft_parity.sv
`timescale 1ns/1ps
module uft_parity
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  frame_cfg_t        cfg,
  output logic              par_bit
);

  logic [DATA_W-1:0] keep;
  logic              ones_odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    if (i < DATA_W - 2) begin : g_always
      assign keep[i] = 1'b1;
    end else if (i == DATA_W - 2) begin : g_seven
      assign keep[i] = (cfg.len_trim != 2'd2);
    end else begin : g_top
      assign keep[i] = (cfg.len_trim == 2'd0);
    end
  end

  assign ones_odd = ^(data & keep);

  always_comb begin
    unique case (cfg.kind)
      PK_EVEN: par_bit = ones_odd;
      PK_ODD:  par_bit = ~ones_odd;
      PK_ZERO: par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/uft_shift_ctrl.sv
`timescale 1ns/1ps
module uft_shift_ctrl
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  frame_cfg_t        cfg,
  input  logic              par_bit,
  output logic              in_ready,
  output logic              txd
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(DATA_W - 1);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic              par_on_q;
  logic              par_q;
  logic              take;

  assign in_ready = (state == ST_IDLE) && tx_en;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      txd      <= 1'b1;
      shreg    <= '0;
      cnt      <= '0;
      last_idx <= FULL_LAST;
      par_on_q <= 1'b0;
      par_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            shreg    <= in_data;
            last_idx <= FULL_LAST - CNT_W'(cfg.len_trim);
            par_on_q <= cfg.par_on;
            par_q    <= par_bit;
            state    <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (tick) begin
            txd   <= 1'b0;
            state <= ST_START;
          end
        end
        ST_START: begin
          if (tick) begin
            txd   <= shreg[0];
            shreg <= shreg >> 1;
            cnt   <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (cnt == last_idx) begin
              if (par_on_q) begin
                txd   <= par_q;
                state <= ST_PAR;
              end else begin
                txd   <= 1'b1;
                state <= ST_STOP;
              end
            end else begin
              txd   <= shreg[0];
              shreg <= shreg >> 1;
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            txd   <= 1'b1;
            state <= ST_STOP;
          end
        end
        default: begin
          if (tick) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_en,
  input  logic [5:1]        mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);

  frame_cfg_t cfg;
  logic       par_bit;

  uft_mode_decode u_dec (
    .mode (mode),
    .cfg  (cfg)
  );

  uft_parity #(.DATA_W(DATA_W)) u_par (
    .data    (in_data),
    .cfg     (cfg),
    .par_bit (par_bit)
  );

  uft_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .tx_en    (tx_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .cfg      (cfg),
    .par_bit  (par_bit),
    .in_ready (in_ready),
    .txd      (txd)
  );

endmodule

// File: rtl/uft_checker.sv
`timescale 1ns/1ps
module uft_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic tx_en,
  input logic in_valid,
  input logic in_ready,
  input logic txd
);

  assert_ready_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_en);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> txd);

  assert_line_steady_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

endmodule

bind uart_frame_tx uft_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .tx_en    (tx_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick;
  logic       tx_en = 1'b1;
  logic [5:1] mode = 5'b10000;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       txd;

  int tests = 0;
  int fails = 0;
  int tcnt = 0;

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tcnt = (tcnt == 3) ? 0 : tcnt + 1;
    end
  end
  assign tick = (tcnt == 0);

  uart_frame_tx #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en), .mode(mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick_edge();
    forever begin
      @(posedge clk);
      if (tick) break;
    end
    @(negedge clk); #1;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic [5:1] m, input int phase,
                            input bit perturb, input bit drop_en, input string req);
    int nb;
    int n;
    bit pon;
    logic pbit;
    logic ones;
    logic [11:0] expv;
    logic [11:0] obs;
    nb = (m[2:1] == 2'b10) ? 7 : (m[2:1] == 2'b11) ? 6 : 8;
    pon = !m[5];
    ones = ^(b & 8'((1 << nb) - 1));
    case (m[4:3])
      2'b00: pbit = ones;
      2'b01: pbit = ~ones;
      2'b10: pbit = 1'b0;
      default: pbit = 1'b1;
    endcase
    expv = '1;
    expv[0] = 1'b0;
    for (int i = 0; i < nb; i++) expv[1+i] = b[i];
    if (pon) expv[1+nb] = pbit;
    n = 2 + nb + (pon ? 1 : 0);
    obs = '1;
    @(negedge clk); #1;
    while (!in_ready || tcnt != phase) begin @(negedge clk); #1; end
    mode = m; in_data = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    in_valid = 1'b0;
    if (perturb) begin mode = ~m; in_data = ~b; end
    if (drop_en) tx_en = 1'b0;
    check(in_ready == 1'b0, "R9 busy after take", in_ready, 0);
    for (int k = 0; k < n; k++) begin
      wait_tick_edge();
      obs[k] = txd;
    end
    check(in_ready == 1'b0, "R9 busy through stop", in_ready, 0);
    check(obs == expv, req, obs, expv);
    wait_tick_edge();
    check(txd == 1'b1 && in_ready == tx_en, "R1 idle after frame", {txd, in_ready}, {1'b1, tx_en});
    if (drop_en) begin
      in_valid = 1'b1;
      repeat (12) begin
        @(negedge clk); #1;
      end
      check(in_ready == 1'b0 && txd == 1'b1, "R8 disabled after frame", {in_ready, txd}, 2'b01);
      in_valid = 1'b0;
      tx_en = 1'b1;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int idx;
    logic [7:0] bl [4];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check(txd == 1'b1 && in_ready == 1'b1, "R1 reset state", {txd, in_ready}, 2'b11);

    // R2 disabled: offers ignored, line high
    begin
      bit bad;
      bad = 0;
      tx_en = 1'b0; in_valid = 1'b1; in_data = 8'h3C;
      repeat (16) begin
        @(negedge clk); #1;
        if (in_ready || !txd) bad = 1;
      end
      check(!bad, "R2 disabled ignores offers", {in_ready, txd}, 2'b01);
      in_valid = 1'b0; tx_en = 1'b1;
    end

    // R3 R4 R5 R6 sweep over every mode code, several bytes, every tick phase
    idx = 0;
    for (int len = 0; len < 4; len++) begin
      for (int par = 0; par < 8; par++) begin
        bl[0] = 8'h00; bl[1] = 8'hFF; bl[2] = 8'hA5;
        bl[3] = 8'(len * 37 + par * 11 + 3);
        for (int j = 0; j < 4; j++) begin
          send_frame(bl[j], {3'(par), 2'(len)}, idx % 4, 0, 0, "R3 R4 R5 R6 frame");
          idx++;
        end
      end
    end

    // R7 mode and data changed right after take
    for (int p = 0; p < 4; p++)
      send_frame(8'h96, 5'b00011, p, 1, 0, "R7 mode sampled at take");
    send_frame(8'h5B, 5'b01010, 2, 1, 0, "R7 mode sampled at take");

    // R8 enable dropped during frame
    send_frame(8'hC3, 5'b00100, 0, 0, 1, "R8 frame completes after enable drop");
    send_frame(8'h81, 5'b01100, 3, 0, 1, "R8 frame completes after enable drop");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule